// File: doc/BRIEF.md
# USB Endpoint Zero-Length Packet Termination Controller

This block tracks one endpoint transfer descriptor from load to retirement. It holds the remaining byte count and subtracts the length of every packet that is moved. It then decides whether the descriptor ends at once, or whether a zero-length packet (ZLP) must first be sent or received.

A ZLP is needed when the final data packet exactly fills the maximum packet size and termination handling is enabled. On transmit the block raises a request to append a ZLP and retires the descriptor once that packet has gone out. On receive the block waits for the host's ZLP. A per-descriptor disable bit turns the extra packet off, and isochronous endpoints never use it.

Top module: `usb_zlp_term`

## Requirements
- R1: After reset `active`, `zlp_req`, `zlp_wait`, `retire` and `unexp_pkt` are 0 and `remaining` is 0.
- R2: `desc_load` while idle captures `desc_bytes` into `remaining` and sets `active` one cycle later. `desc_load` while active is ignored, and `remaining` is unchanged.
- R3: Each packet accepted during the data phase reduces `remaining` by `pkt_len`, saturating at 0.
- R4: A data-phase packet with `pkt_len < max_pkt` pulses `retire` on the next cycle and returns the block to idle, whatever the disable bit.
- R5: On transmit (`dir_tx`=1), with termination enabled, a data packet with `pkt_len >= max_pkt` that brings `remaining` to 0 raises `zlp_req`. The request holds until the next `pkt_valid`, which is the ZLP being sent. That packet pulses `retire`.
- R6: On receive (`dir_tx`=0), the same condition raises `zlp_wait`. A packet with `pkt_len` = 0 then pulses `retire`.
- R7: With termination disabled (`desc_zlt_off`=1), a full packet that brings `remaining` to 0 retires directly, with no `zlp_req` and no `zlp_wait`.
- R8: With `ep_iso`=1 the disable bit has no effect and no ZLP is ever requested or awaited.
- R9: A packet while idle, or a non-zero packet while waiting for a ZLP, pulses `unexp_pkt`. It retires nothing and leaves the state unchanged.
- R10: `zlp_req` and `zlp_wait` are never high together, and `retire` lasts exactly one cycle.
- R11: The disable bit is sampled at `desc_load`. Later changes of `desc_zlt_off` do not affect that descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_load | input | 1 | Load a new descriptor |
| desc_bytes | input | CNT_W | Total byte count of the descriptor |
| desc_zlt_off | input | 1 | 1 disables ZLP termination for this descriptor |
| max_pkt | input | MPS_W | Endpoint maximum packet size |
| ep_iso | input | 1 | Endpoint is isochronous |
| dir_tx | input | 1 | 1 transmit, 0 receive |
| pkt_valid | input | 1 | One packet moved this cycle |
| pkt_len | input | MPS_W | Length of that packet |
| active | output | 1 | A descriptor is in progress |
| zlp_req | output | 1 | Append a ZLP (transmit) |
| zlp_wait | output | 1 | Waiting for a ZLP (receive) |
| retire | output | 1 | Descriptor retired (pulse) |
| unexp_pkt | output | 1 | Unexpected packet (pulse) |
| remaining | output | CNT_W | Remaining byte count |

## Verification
Transfers are run in both directions. Each is ended three ways: by a short packet, by an exact multiple of the packet size with termination on, and by the same multiple with termination off. Comparing these separates the short-packet rule from the full-packet rule. Isochronous runs show that the disable bit is ignored there. A count smaller than one packet exercises saturation. Stray packets, a reload during a transfer and a flip of the disable bit mid-transfer show that idle and waiting states, and the per-descriptor capture, cannot be disturbed.

// File: rtl/usb_zlp_term.sv
module usb_zlp_term #(
  parameter int CNT_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_load,
  input  logic [CNT_W-1:0] desc_bytes,
  input  logic             desc_zlt_off,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             ep_iso,
  input  logic             dir_tx,
  input  logic             pkt_valid,
  input  logic [MPS_W-1:0] pkt_len,
  output logic             active,
  output logic             zlp_req,
  output logic             zlp_wait,
  output logic             retire,
  output logic             unexp_pkt,
  output logic [CNT_W-1:0] remaining
);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TXZ, S_RXW} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt_q;
  logic             zoff_q;
  logic             ret_q;
  logic             unx_q;

  logic [CNT_W-1:0] len_ext;
  logic [CNT_W-1:0] cnt_next;
  logic             is_short;
  logic             zlt_use;

  assign len_ext  = CNT_W'(pkt_len);
  assign cnt_next = (len_ext >= cnt_q) ? '0 : cnt_q - len_ext;
  assign is_short = pkt_len < max_pkt;
  assign zlt_use  = !zoff_q && !ep_iso;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt_q  <= '0;
      zoff_q <= 1'b0;
      ret_q  <= 1'b0;
      unx_q  <= 1'b0;
    end else begin
      ret_q <= 1'b0;
      unx_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (desc_load) begin
            cnt_q  <= desc_bytes;
            zoff_q <= desc_zlt_off;
            st     <= S_DATA;
          end else if (pkt_valid) begin
            unx_q <= 1'b1;
          end
        end
        S_DATA: begin
          if (pkt_valid) begin
            cnt_q <= cnt_next;
            if (is_short || (cnt_next == '0 && !zlt_use)) begin
              ret_q <= 1'b1;
              st    <= S_IDLE;
            end else if (cnt_next == '0) begin
              st <= dir_tx ? S_TXZ : S_RXW;
            end
          end
        end
        S_TXZ: begin
          if (pkt_valid) begin
            ret_q <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_RXW: begin
          if (pkt_valid) begin
            if (pkt_len == '0) begin
              ret_q <= 1'b1;
              st    <= S_IDLE;
            end else begin
              unx_q <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign active    = (st != S_IDLE);
  assign zlp_req   = (st == S_TXZ);
  assign zlp_wait  = (st == S_RXW);
  assign retire    = ret_q;
  assign unexp_pkt = unx_q;
  assign remaining = cnt_q;

endmodule

// File: rtl/usb_zlp_term_chk.sv
module usb_zlp_term_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             active,
  input logic             zlp_req,
  input logic             zlp_wait,
  input logic             retire,
  input logic             unexp_pkt,
  input logic [CNT_W-1:0] remaining
);

  a_r10_req_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(zlp_req && zlp_wait));

  a_r10_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  a_r3_count_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (!active || remaining <= $past(remaining)));

  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (zlp_req && !pkt_valid) |=> zlp_req);

  a_r9_unexp_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_pkt |-> !retire);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!zlp_req && !zlp_wait));

endmodule

bind usb_zlp_term usb_zlp_term_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .active(active),
  .zlp_req(zlp_req), .zlp_wait(zlp_wait), .retire(retire),
  .unexp_pkt(unexp_pkt), .remaining(remaining)
);

// File: tb/usb_zlp_term_tb.sv
module usb_zlp_term_tb;
  localparam int CNT_W = 16;
  localparam int MPS_W = 11;

  logic clk = 0;
  logic rst_n = 0;
  logic desc_load = 0;
  logic [CNT_W-1:0] desc_bytes = '0;
  logic desc_zlt_off = 0;
  logic [MPS_W-1:0] max_pkt = 11'd64;
  logic ep_iso = 0;
  logic dir_tx = 0;
  logic pkt_valid = 0;
  logic [MPS_W-1:0] pkt_len = '0;
  logic active, zlp_req, zlp_wait, retire, unexp_pkt;
  logic [CNT_W-1:0] remaining;

  always #2 clk = ~clk;

  usb_zlp_term #(.CNT_W(CNT_W), .MPS_W(MPS_W)) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 data, 2 tx zlp, 3 rx wait
  int m_st = 0, m_cnt = 0, m_off = 0, m_ret = 0, m_unx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_off = 0; m_ret = 0; m_unx = 0;
    end else begin
      int len, nc;
      m_ret = 0; m_unx = 0;
      len = int'(pkt_len);
      if (m_st == 0) begin
        if (desc_load) begin m_cnt = int'(desc_bytes); m_off = int'(desc_zlt_off); m_st = 1; end
        else if (pkt_valid) m_unx = 1;
      end else if (m_st == 1) begin
        if (pkt_valid) begin
          nc = (len >= m_cnt) ? 0 : m_cnt - len;
          m_cnt = nc;
          if (len < int'(max_pkt)) begin m_ret = 1; m_st = 0; end
          else if (nc == 0) begin
            if (m_off == 1 || ep_iso) begin m_ret = 1; m_st = 0; end
            else m_st = dir_tx ? 2 : 3;
          end
        end
      end else if (m_st == 2) begin
        if (pkt_valid) begin m_ret = 1; m_st = 0; end
      end else begin
        if (pkt_valid) begin
          if (len == 0) begin m_ret = 1; m_st = 0; end
          else m_unx = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 active", int'(active), int'(m_st != 0));
      chk("R3 remaining", int'(remaining), m_cnt);
      chk("R5 zlp_req", int'(zlp_req), int'(m_st == 2));
      chk("R6 zlp_wait", int'(zlp_wait), int'(m_st == 3));
      chk("R4 retire", int'(retire), m_ret);
      chk("R9 unexp_pkt", int'(unexp_pkt), m_unx);
    end
  end

  task automatic load(input int bytes, input bit off);
    @(negedge clk); desc_load = 1; desc_bytes = CNT_W'(bytes); desc_zlt_off = off;
    @(negedge clk); desc_load = 0;
  endtask

  task automatic send(input int len);
    @(negedge clk); pkt_valid = 1; pkt_len = MPS_W'(len);
    @(negedge clk); pkt_valid = 0;
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 active", int'(active), 0);
    chk("R1 remaining", int'(remaining), 0);
    chk("R1 retire", int'(retire), 0);

    // R4 short packet on transmit
    dir_tx = 1;
    load(100, 0);
    chk("R2 load", int'(remaining), 100);
    send(64);
    chk("R3 subtract", int'(remaining), 36);
    send(36);
    chk("R4 short retire", int'(retire), 1);
    @(negedge clk);
    chk("R10 retire one cycle", int'(retire), 0);

    // R5 transmit ZLP
    load(128, 0);
    send(64); send(64);
    chk("R5 req raised", int'(zlp_req), 1);
    chk("R5 no retire yet", int'(retire), 0);
    repeat (3) @(negedge clk);
    chk("R5 req holds", int'(zlp_req), 1);
    send(0);
    chk("R5 retire after zlp", int'(retire), 1);
    chk("R5 req cleared", int'(zlp_req), 0);

    // R6 receive ZLP with stray data R9
    dir_tx = 0;
    load(128, 0);
    send(64); send(64);
    chk("R6 wait raised", int'(zlp_wait), 1);
    send(10);
    chk("R9 nonzero while waiting", int'(unexp_pkt), 1);
    chk("R9 still waiting", int'(zlp_wait), 1);
    send(0);
    chk("R6 retire on zlp", int'(retire), 1);

    // R7 disabled, both directions
    load(128, 1);
    send(64); send(64);
    chk("R7 rx retire direct", int'(retire), 1);
    chk("R7 rx no wait", int'(zlp_wait), 0);
    dir_tx = 1;
    load(128, 1);
    send(64); send(64);
    chk("R7 tx retire direct", int'(retire), 1);
    chk("R7 tx no req", int'(zlp_req), 0);

    // R8 isochronous ignores enabled termination
    ep_iso = 1;
    load(64, 0);
    send(64);
    chk("R8 iso tx retire", int'(retire), 1);
    dir_tx = 0;
    load(128, 0);
    send(64); send(64);
    chk("R8 iso rx retire", int'(retire), 1);
    chk("R8 iso no wait", int'(zlp_wait), 0);
    ep_iso = 0;

    // R3 saturation
    load(50, 0);
    send(64);
    chk("R3 saturate", int'(remaining), 0);
    chk("R6 wait after saturate", int'(zlp_wait), 1);
    send(0);

    // R2 reload ignored while active
    load(100, 0);
    load(20, 0);
    chk("R2 reload ignored", int'(remaining), 100);
    send(4);

    // R11 mid-transfer flip of disable bit
    dir_tx = 1;
    load(64, 0);
    @(negedge clk); desc_zlt_off = 1;
    send(64);
    chk("R11 captured bit", int'(zlp_req), 1);
    send(0);
    desc_zlt_off = 0;

    // R9 packet while idle
    send(8);
    chk("R9 idle packet", int'(unexp_pkt), 1);
    chk("R9 idle stays idle", int'(active), 0);
    send(0);
    chk("R9 idle zlp", int'(unexp_pkt), 1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule